// File: doc/BRIEF.md
# Pulse Capture Completeness Checker

This block watches up to sixteen sensor lines that each produce only a short pulse. Every line has a sticky flag that is set by a pulse and then holds, whatever the line does afterwards. One common clear input drops all flags together. The first flag to be set opens a check window of fixed length. When that window ends, the block compares the flag pattern with a mask of the channels expected to fire. It reports the verdict as a one-cycle pass or fail strobe.

The pulse inputs are asynchronous. Each one passes through a two-flop synchroniser, and a rising-edge detector after it sets the flag, so a pulse must be at least two clock periods wide. A chip enable deselects the block without changing its stored state. While it is low, the outputs are forced inactive, new edges are dropped and the window timer holds its count. The window length is given in clock cycles; for example, four seconds at 50 MHz is 200,000,000 cycles.

Top module: `pulse_audit`

## Requirements
- R1: After the asynchronous reset `rst_ni`, `flags_o` is all zero and `window_o`, `pass_o` and `fail_o` are low.
- R2: A high pulse of at least two cycles on `pulse_i[k]`, with the block enabled, sets `flags_o[k]` on the third rising clock edge after the input rises. The flag stays set after the input falls.
- R3: A cycle with `clr_i` high clears every flag at the next edge and returns the window logic to idle, so a later capture opens a new window.
- R4: `window_o` rises one cycle after the first flag is set and stays high for exactly `WIN_CYC` enabled cycles.
- R5: In the last cycle of the window, `pass_o` pulses for one cycle if `flags_o` equals `mask_i` bit for bit.
- R6: In the last cycle of the window, `fail_o` pulses for one cycle if a channel set in `mask_i` has no flag, or if a channel cleared in `mask_i` has a flag.
- R7: After a verdict, no window opens and no strobe is issued until `clr_i` has been applied, even if more channels capture.
- R8: While `en_i` is low, `flags_o` is zero and `window_o`, `pass_o` and `fail_o` are low. Input edges that arrive while `en_i` is low never set a flag.
- R9: While `en_i` is low, the window count holds. Enabled window cycles before and after the pause add up to `WIN_CYC`, and the stored flags return when `en_i` goes high again.
- R10: When `clr_i` and a capture edge fall in the same cycle, the clear wins and the flag stays zero.
- R11: `pass_o` and `fail_o` are never high together, each lasts one cycle, and each is only issued while `window_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous common clear of flags and window |
| en_i | input | 1 | Chip enable; low deselects the block |
| pulse_i | input | N_CH | Asynchronous sensor pulses |
| mask_i | input | N_CH | Expected channels, 1 = must fire |
| flags_o | output | N_CH | Sticky capture flags |
| window_o | output | 1 | Check window running |
| pass_o | output | 1 | One-cycle strobe: pattern matched |
| fail_o | output | 1 | One-cycle strobe: pattern mismatched |

## Verification
The hardest situations to reach are a clear that lands in exactly the cycle where a synchronised edge would set a flag, and a chip-enable pause that falls in the middle of a running window. The bench times the clear from the known three-edge capture latency, so `clr_i` is high during the rising-edge cycle. It drops `en_i` after a counted number of window cycles and checks that the enabled window cycles before and after the pause add up to the configured length.

// File: rtl/pulse_audit_pkg.sv
package pulse_audit_pkg;
  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_RUN  = 2'd1,
    WIN_DONE = 2'd2
  } win_state_e;
endpackage

// File: rtl/pa_sync_edge.sv
module pa_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // last synchronised stage high, one beyond it still low
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pa_flag_bank.sv
module pa_flag_bank #(
  parameter int N_CH = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [N_CH-1:0] rise_i,
  output logic [N_CH-1:0] flags_o,
  output logic            any_o
);
  logic [N_CH-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (clr_i) flags_q <= '0;  // clear beats a same-cycle capture
    else if (en_i)  flags_q <= flags_q | rise_i;
  end

  assign flags_o = flags_q;
  assign any_o   = |flags_q;
endmodule

// File: rtl/pa_window.sv
module pa_window
  import pulse_audit_pkg::*;
#(
  parameter int WIN_CYC = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  input  logic any_i,
  output logic window_o,
  output logic last_o
);
  localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  win_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      st_d  = WIN_IDLE;
      cnt_d = '0;
    end else if (en_i) begin
      unique case (st_q)
        WIN_IDLE: if (any_i) begin
          st_d  = WIN_RUN;
          cnt_d = '0;
        end
        WIN_RUN: begin
          if (cnt_q == LAST) st_d = WIN_DONE;
          else               cnt_d = cnt_q + 1'b1;
        end
        WIN_DONE: st_d = WIN_DONE;  // holds until clear
        default:  st_d = WIN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WIN_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign window_o = (st_q == WIN_RUN);
  assign last_o   = window_o && (cnt_q == LAST) && en_i && !clr_i;
endmodule

// File: rtl/pa_verdict.sv
module pa_verdict #(
  parameter int N_CH = 16
) (
  input  logic            last_i,
  input  logic [N_CH-1:0] flags_i,
  input  logic [N_CH-1:0] mask_i,
  output logic            pass_o,
  output logic            fail_o
);
  logic missing, extra;

  assign missing = |(mask_i & ~flags_i);
  assign extra   = |(~mask_i & flags_i);
  assign pass_o  = last_i && !missing && !extra;
  assign fail_o  = last_i && (missing || extra);
endmodule

// File: rtl/pulse_audit.sv
module pulse_audit #(
  parameter int N_CH     = 16,
  parameter int SYNC_STG = 2,
  parameter int WIN_CYC  = 200_000_000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            en_i,
  input  logic [N_CH-1:0] pulse_i,
  input  logic [N_CH-1:0] mask_i,
  output logic [N_CH-1:0] flags_o,
  output logic            window_o,
  output logic            pass_o,
  output logic            fail_o
);
  logic [N_CH-1:0] rise;
  logic [N_CH-1:0] flags;
  logic            any_flag, win, last;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pa_sync_edge #(.STAGES(SYNC_STG)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pulse_i[g]),
      .rise_o(rise[g])
    );
  end

  pa_flag_bank #(.N_CH(N_CH)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .en_i   (en_i),
    .rise_i (rise),
    .flags_o(flags),
    .any_o  (any_flag)
  );

  pa_window #(.WIN_CYC(WIN_CYC)) u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .en_i    (en_i),
    .any_i   (any_flag),
    .window_o(win),
    .last_o  (last)
  );

  pa_verdict #(.N_CH(N_CH)) u_verdict (
    .last_i (last),
    .flags_i(flags),
    .mask_i (mask_i),
    .pass_o (pass_o),
    .fail_o (fail_o)
  );

  assign flags_o  = en_i ? flags : '0;
  assign window_o = en_i & win;
endmodule

// File: rtl/pulse_audit_chk.sv
module pulse_audit_chk #(
  parameter int N_CH = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clr_i,
  input logic            en_i,
  input logic [N_CH-1:0] mask_i,
  input logic [N_CH-1:0] flags_o,
  input logic            window_o,
  input logic            pass_o,
  input logic            fail_o
);
  logic verdict_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                verdict_seen_q <= 1'b0;
    else if (clr_i)             verdict_seen_q <= 1'b0;
    else if (pass_o || fail_o)  verdict_seen_q <= 1'b1;
  end

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && fail_o));
  a_r11_pass_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);
  a_r11_fail_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
  a_r11_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> window_o);
  a_r5_pass_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> (flags_o == mask_i));
  a_r6_fail_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (flags_o != mask_i));
  a_r7_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o) |-> !verdict_seen_q);
  a_r8_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (flags_o == '0) && !window_o && !pass_o && !fail_o);
  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (flags_o == '0) && !window_o);
  a_r2_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(clr_i)) |-> ((flags_o & $past(flags_o)) == $past(flags_o)));
endmodule

bind pulse_audit pulse_audit_chk #(.N_CH(N_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .clr_i   (clr_i),
  .en_i    (en_i),
  .mask_i  (mask_i),
  .flags_o (flags_o),
  .window_o(window_o),
  .pass_o  (pass_o),
  .fail_o  (fail_o)
);

// File: tb/sim_pulse_audit.sv
module sim_pulse_audit;
  localparam int N   = 16;
  localparam int WIN = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         en = 1'b1;
  logic [N-1:0] pulse = '0;
  logic [N-1:0] mask = '0;
  logic [N-1:0] flags;
  logic         win, pass, fail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pulse_audit #(.N_CH(N), .SYNC_STG(2), .WIN_CYC(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .en_i(en),
    .pulse_i(pulse), .mask_i(mask),
    .flags_o(flags), .window_o(win), .pass_o(pass), .fail_o(fail)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_clear();
    clr = 1'b1;
    step();
    clr = 1'b0;
  endtask

  task automatic pulse_on(logic [N-1:0] b, int w);
    pulse = pulse | b;
    step(w);
    pulse = pulse & ~b;
  endtask

  // counts window cycles and strobes; flags strobes outside window or doubled
  task automatic observe(int n, output int wc, output int pc, output int fc, output int bad);
    wc = 0; pc = 0; fc = 0; bad = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (win)  wc++;
      if (pass) pc++;
      if (fail) fc++;
      if ((pass || fail) && !win) bad++;
      if (pass && fail) bad++;
    end
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(flags), 32'h0);
    chk("R1 window", 32'(win), 32'h0);
    chk("R1 strobes", 32'({pass, fail}), 32'h0);
  endtask

  task automatic t_single_capture();
    int wc, pc, fc, bad;
    do_clear();
    mask = 16'h0009;
    pulse = 16'h0008;
    step();
    chk("R2 flag not yet (edge1)", 32'(flags), 32'h0);
    step();
    chk("R2 flag not yet (edge2)", 32'(flags), 32'h0);
    pulse = '0;
    step();
    chk("R2 flag set on edge3", 32'(flags), 32'h0008);
    chk("R4 window not yet", 32'(win), 32'h0);
    observe(WIN + 4, wc, pc, fc, bad);
    chk("R4 window length", 32'(wc), 32'(WIN));
    chk("R6 missing channel fails", 32'(fc), 32'h1);
    chk("R5 no pass", 32'(pc), 32'h0);
    chk("R11 strobe placement", 32'(bad), 32'h0);
    chk("R2 sticky", 32'(flags), 32'h0008);
  endtask

  task automatic t_pass();
    int wc, pc, fc, bad;
    do_clear();
    mask = 16'h0005;
    pulse_on(16'h0001, 2);
    pulse_on(16'h0004, 3);
    observe(WIN + 8, wc, pc, fc, bad);
    chk("R5 pass strobe", 32'(pc), 32'h1);
    chk("R5 no fail", 32'(fc), 32'h0);
    chk("R11 strobe placement", 32'(bad), 32'h0);
    chk("R5 flags", 32'(flags), 32'h0005);
  endtask

  task automatic t_missing();
    int wc, pc, fc, bad;
    do_clear();
    mask = 16'h0007;
    pulse_on(16'h0001, 2);
    pulse_on(16'h0004, 2);
    observe(WIN + 8, wc, pc, fc, bad);
    chk("R6 missing fail", 32'(fc), 32'h1);
    chk("R6 missing no pass", 32'(pc), 32'h0);
  endtask

  task automatic t_extra_and_norestart();
    int wc, pc, fc, bad;
    do_clear();
    mask = 16'h0005;
    pulse_on(16'h0205, 2);
    observe(WIN + 8, wc, pc, fc, bad);
    chk("R6 extra fail", 32'(fc), 32'h1);
    chk("R6 extra no pass", 32'(pc), 32'h0);
    // later capture after verdict
    pulse_on(16'h0020, 2);
    observe(3 * WIN, wc, pc, fc, bad);
    chk("R7 no new window", 32'(wc), 32'h0);
    chk("R7 no new strobe", 32'(pc + fc), 32'h0);
    chk("R7 capture still sticks", 32'(flags), 32'h0225);
    do_clear();
    chk("R3 all flags cleared", 32'(flags), 32'h0);
    mask = 16'h0002;
    pulse_on(16'h0002, 2);
    observe(WIN + 6, wc, pc, fc, bad);
    chk("R3 window reopens", 32'(wc), 32'(WIN));
    chk("R3 new verdict pass", 32'(pc), 32'h1);
  endtask

  task automatic t_clr_priority();
    int wc, pc, fc, bad;
    do_clear();
    mask = 16'h0001;
    pulse = 16'h0001;
    step(2);
    clr = 1'b1;  // high in the edge-detect cycle
    step();
    clr = 1'b0;
    pulse = '0;
    step();
    chk("R10 clear beats capture", 32'(flags), 32'h0);
    observe(WIN + 4, wc, pc, fc, bad);
    chk("R10 no window", 32'(wc), 32'h0);
  endtask

  task automatic t_disable();
    int wc, pc, fc, bad;
    do_clear();
    mask = 16'h0002;
    en = 1'b0;
    pulse_on(16'h0002, 3);
    step(2);
    chk("R8 flags forced low", 32'(flags), 32'h0);
    chk("R8 window low", 32'(win), 32'h0);
    en = 1'b1;
    step(3);
    chk("R8 edge while off ignored", 32'(flags), 32'h0);
    chk("R8 no window after", 32'(win), 32'h0);
    pulse_on(16'h0002, 2);
    step();
    chk("R8 capture when on", 32'(flags), 32'h0002);
    en = 1'b0;
    step();
    chk("R8 flags hidden", 32'(flags), 32'h0);
    en = 1'b1;
    step();
    chk("R9 flags return", 32'(flags), 32'h0002);
    observe(WIN + 4, wc, pc, fc, bad);
  endtask

  task automatic t_freeze();
    int wc, pc, fc, bad;
    do_clear();
    mask = 16'h0001;
    pulse_on(16'h0001, 2);
    step();
    observe(3, wc, pc, fc, bad);
    chk("R4 window running", 32'(wc), 32'h3);
    en = 1'b0;
    observe(20, wc, pc, fc, bad);
    chk("R8 paused outputs", 32'(wc + pc + fc), 32'h0);
    en = 1'b1;
    observe(WIN + 4, wc, pc, fc, bad);
    chk("R9 remaining window", 32'(wc), 32'(WIN - 3));
    chk("R9 verdict after pause", 32'(pc), 32'h1);
    chk("R11 strobe placement", 32'(bad), 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_single_capture();
    t_pass();
    t_missing();
    t_extra_and_norestart();
    t_clr_priority();
    t_disable();
    t_freeze();
    // async reset mid-run returns to the R1 state
    pulse_on(16'h0010, 2);
    step(2);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    t_reset();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end
endmodule